// File: doc/BRIEF.md
# Phase-Driven Analog Power-Gating Controller

This block drives the enable lines of the analog helpers around a current-mode buck regulator. It switches off, one switching phase at a time, the parts that cannot influence the present decision. While the high-side switch conducts, nothing needs to watch for reverse inductor current. While the low-side switch conducts in fixed-frequency operation, the peak-current path and the ramp path are idle. In pulse-skipping operation the loop amplifier, the oscillator and the ramp chain are never needed. When both switches are open in pulse-skipping operation, only the output-voltage comparator has to watch.

Fixed-frequency operation brings two more needs. A free-running period counter, restarted by the oscillator pulse, re-enables the ramp path, the peak-current path and the over-voltage comparator a set number of system clocks before the next cycle starts. The current-sense front end receives a short preset pulse whenever it is switched off, so that its first reading after it comes back on is valid.

Until start-up has finished, every helper stays on. Every enable is registered, so outputs change one system clock after an input changes and carry no glitches.

Top module: `dyn_gate_top`

## Requirements
- R1: While `rstN` is low, `gateEn` is all ones and `csPreset` is low.
- R2: While `ssDone` is low, all eleven enable bits are high one clock later, whatever the mode and the phase. The bit order is: 0 current sense, 1 over-current comparator, 2 reverse-current detector, 3 over-voltage comparator, 4 ramp generator, 5 ramp adder, 6 modulator, 7 error amplifier, 8 oscillator, 9 voltage comparator, 10 soft-start.
- R3: Once `ssDone` is high, bit 10 is low in every mode and phase.
- R4: In fixed-frequency mode (`pfmMode`=0) with the high-side switch on, only bits 2 and 10 are low (value 0x3FB).
- R5: In fixed-frequency mode with the low-side switch on, or with both switches off, and outside the wake window, the value is 0x384: only bits 2, 7, 8 and 9 are high.
- R6: In pulse-skipping mode (`pfmMode`=1), bits 4 to 8 and bit 10 are always low. The value is 0x20B with the high-side switch on, 0x20C with the low-side switch on, and 0x200 with both switches off.
- R7: In fixed-frequency mode, when the high-side switch is not on and the period counter is at or above `PERIOD_CLKS-WAKE_LEAD`, bits 0, 1, 3, 4, 5 and 6 are also high (value 0x3FF).
- R8: `cycleSync` resets the period counter to 0. Otherwise the counter increments and holds at `PERIOD_CLKS-1`. With the defaults (50, 4), the wake bits rise 47 clocks after the clock that samples `cycleSync`, and stay high until the clock after the next sync.
- R9: Every output changes on the first rising clock edge after the input change, and not before.
- R10: `csPreset` goes high in the same cycle that bit 0 falls. It stays high for `PRESET_LEN` cycles (default 2), and is cut short if bit 0 rises again first.
- R11: If `hsOn` and `lsOn` are both high, the block treats the phase as high-side on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| pfmMode | input | 1 | 1 = pulse-skipping mode, 0 = fixed-frequency mode |
| hsOn | input | 1 | High-side switch conducting |
| lsOn | input | 1 | Low-side switch conducting |
| ssDone | input | 1 | Start-up ramp complete |
| cycleSync | input | 1 | Oscillator pulse marking a switching-period start |
| gateEn | output | 11 | Registered enables, bit order as in R2 |
| csPreset | output | 1 | Preset strobe for the current-sense front end |

## Verification
A wrong phase decode or mode mask shows at once as a wrong `gateEn` word, one clock after the phase inputs change. A period counter that runs off count shows as wake bits that rise early, late or not at all, measured against the count since `cycleSync`. A wrong preset counter shows in the length of the `csPreset` pulse within two or three clocks of a falling current-sense enable.

// File: rtl/dg_pkg.sv
package dg_pkg;

  localparam int N_GATES = 11;

  localparam int G_CSENSE = 0;
  localparam int G_OCP    = 1;
  localparam int G_REVDET = 2;
  localparam int G_OVP    = 3;
  localparam int G_RAMP   = 4;
  localparam int G_ADDER  = 5;
  localparam int G_MODUL  = 6;
  localparam int G_ERRAMP = 7;
  localparam int G_OSC    = 8;
  localparam int G_VCMP   = 9;
  localparam int G_SSTART = 10;

  typedef enum logic [1:0] {
    PH_OPEN = 2'd0,
    PH_HIGH = 2'd1,
    PH_LOW  = 2'd2
  } phase_t;

  typedef struct packed {
    logic   ssDone;
    logic   pfmMode;
    phase_t phase;
    logic   leadWake;
  } gateStrobe_t;

endpackage

// File: rtl/dg_ctrl.sv
module dg_ctrl
  import dg_pkg::*;
#(
  parameter int PERIOD_CLKS = 50,
  parameter int WAKE_LEAD   = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pfmMode,
  input  logic        hsOn,
  input  logic        lsOn,
  input  logic        ssDone,
  input  logic        cycleSync,
  output gateStrobe_t strb
);

  localparam int CW = (PERIOD_CLKS > 1) ? $clog2(PERIOD_CLKS) : 1;
  localparam int WAKE_START = PERIOD_CLKS - WAKE_LEAD;
  localparam logic [CW-1:0] CNT_TOP = CW'(PERIOD_CLKS - 1);

  logic [CW-1:0] periodCnt;
  phase_t        phaseNow;

  // high-side wins when both flags are set (R11)
  always_comb begin
    if (hsOn)      phaseNow = PH_HIGH;
    else if (lsOn) phaseNow = PH_LOW;
    else           phaseNow = PH_OPEN;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                   periodCnt <= '0;
    else if (cycleSync)          periodCnt <= '0;
    else if (periodCnt != CNT_TOP) periodCnt <= periodCnt + 1'b1;
  end

  always_comb begin
    strb.ssDone   = ssDone;
    strb.pfmMode  = pfmMode;
    strb.phase    = phaseNow;
    strb.leadWake = (int'(periodCnt) >= WAKE_START);
  end

  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    periodCnt <= CNT_TOP);

  assert_sync_restart_R8: assert property (@(posedge clk) disable iff (!rstN)
    cycleSync |=> (periodCnt == '0));

  assert_hs_priority_R11: assert property (@(posedge clk) disable iff (!rstN)
    hsOn |-> (strb.phase == PH_HIGH));

endmodule

// File: rtl/dg_datapath.sv
module dg_datapath
  import dg_pkg::*;
#(
  parameter int PRESET_LEN = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  gateStrobe_t        strb,
  output logic [N_GATES-1:0] gateEn,
  output logic               csPreset
);

  localparam int PCW = $clog2(PRESET_LEN + 1);
  localparam logic [N_GATES-1:0] ALL_ON  = '1;
  localparam logic [N_GATES-1:0] B1      = N_GATES'(1);
  localparam logic [N_GATES-1:0] RAMP_SET =
    (B1 << G_RAMP) | (B1 << G_ADDER) | (B1 << G_MODUL);
  localparam logic [N_GATES-1:0] PEAK_SET =
    (B1 << G_CSENSE) | (B1 << G_OCP);
  localparam logic [N_GATES-1:0] PWM_HIGH = ALL_ON & ~(B1 << G_REVDET) & ~(B1 << G_SSTART);
  localparam logic [N_GATES-1:0] PWM_LOW  =
    PWM_HIGH & ~PEAK_SET & ~(B1 << G_OVP) & ~RAMP_SET | (B1 << G_REVDET);
  localparam logic [N_GATES-1:0] PWM_WAKE = PEAK_SET | (B1 << G_OVP) | RAMP_SET;
  localparam logic [N_GATES-1:0] PFM_HIGH = PEAK_SET | (B1 << G_OVP) | (B1 << G_VCMP);
  localparam logic [N_GATES-1:0] PFM_LOW  = (B1 << G_REVDET) | (B1 << G_OVP) | (B1 << G_VCMP);
  localparam logic [N_GATES-1:0] PFM_OPEN = (B1 << G_VCMP);

  logic [N_GATES-1:0] enNext;
  logic [PCW-1:0]     presetLeft;

  always_comb begin
    if (!strb.ssDone) begin
      enNext = ALL_ON;
    end else if (strb.pfmMode) begin
      unique case (strb.phase)
        PH_HIGH: enNext = PFM_HIGH;
        PH_LOW:  enNext = PFM_LOW;
        default: enNext = PFM_OPEN;
      endcase
    end else begin
      if (strb.phase == PH_HIGH)  enNext = PWM_HIGH;
      else if (strb.leadWake)     enNext = PWM_LOW | PWM_WAKE;
      else                        enNext = PWM_LOW;
    end
  end

  genvar g;
  generate
    for (g = 0; g < N_GATES; g++) begin : gEnReg
      always_ff @(posedge clk) begin
        if (!rstN) gateEn[g] <= 1'b1;
        else       gateEn[g] <= enNext[g];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csPreset   <= 1'b0;
      presetLeft <= '0;
    end else if (!enNext[G_CSENSE]) begin
      if (gateEn[G_CSENSE]) begin
        csPreset   <= 1'b1;
        presetLeft <= PCW'(PRESET_LEN - 1);
      end else if (presetLeft != '0) begin
        csPreset   <= 1'b1;
        presetLeft <= presetLeft - 1'b1;
      end else begin
        csPreset   <= 1'b0;
      end
    end else begin
      csPreset   <= 1'b0;
      presetLeft <= '0;
    end
  end

  assert_startup_all_on_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.ssDone |=> (gateEn == ALL_ON));

  assert_sstart_off_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.ssDone |=> !gateEn[G_SSTART]);

  assert_pfm_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ssDone && strb.pfmMode) |=> (gateEn[G_MODUL:G_RAMP] == '0 && !gateEn[G_ERRAMP] && !gateEn[G_OSC]));

  assert_preset_on_fall_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(gateEn[G_CSENSE]) |-> csPreset);

  assert_preset_only_off_R10: assert property (@(posedge clk) disable iff (!rstN)
    csPreset |-> !gateEn[G_CSENSE]);

endmodule

// File: rtl/dyn_gate_top.sv
module dyn_gate_top
  import dg_pkg::*;
#(
  parameter int PERIOD_CLKS = 50,
  parameter int WAKE_LEAD   = 4,
  parameter int PRESET_LEN  = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pfmMode,
  input  logic        hsOn,
  input  logic        lsOn,
  input  logic        ssDone,
  input  logic        cycleSync,
  output logic [10:0] gateEn,
  output logic        csPreset
);

  gateStrobe_t strb;

  dg_ctrl #(.PERIOD_CLKS(PERIOD_CLKS), .WAKE_LEAD(WAKE_LEAD)) uCtrl (
    .clk(clk), .rstN(rstN), .pfmMode(pfmMode), .hsOn(hsOn), .lsOn(lsOn),
    .ssDone(ssDone), .cycleSync(cycleSync), .strb(strb)
  );

  dg_datapath #(.PRESET_LEN(PRESET_LEN)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .gateEn(gateEn), .csPreset(csPreset)
  );

  assert_reset_state_R1: assert property (@(posedge clk)
    !rstN |=> (gateEn == 11'h7FF && !csPreset));

endmodule

// File: tb/tb_dyn_gate_top.sv
module tb_dyn_gate_top;

  logic clk = 1'b0;
  logic rstN, pfmMode, hsOn, lsOn, ssDone, cycleSync;
  logic [10:0] gateEn;
  logic csPreset;
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dyn_gate_top dut (
    .clk(clk), .rstN(rstN), .pfmMode(pfmMode), .hsOn(hsOn), .lsOn(lsOn),
    .ssDone(ssDone), .cycleSync(cycleSync), .gateEn(gateEn), .csPreset(csPreset)
  );

  // vector: {pfmMode, hsOn, lsOn, ssDone, expected gateEn}
  localparam int NV = 10;
  localparam logic [14:0] VEC [NV] = '{
    {4'b0100, 11'h7FF},  // R2
    {4'b1000, 11'h7FF},  // R2
    {4'b0101, 11'h3FB},  // R4, R3
    {4'b0011, 11'h384},  // R5
    {4'b0001, 11'h384},  // R5
    {4'b1101, 11'h20B},  // R6
    {4'b1011, 11'h20C},  // R6
    {4'b1001, 11'h200},  // R6
    {4'b0111, 11'h3FB},  // R11
    {4'b1111, 11'h20B}   // R11
  };

  function automatic string vecTag(int i);
    case (i)
      0, 1:    return "R2";
      2:       return "R4";
      3, 4:    return "R5";
      5, 6, 7: return "R6";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string tag, input logic [10:0] act, input logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%03h expected 0x%03h", tag, act, exp);
    end
  endtask

  task automatic setIn(input logic p, input logic h, input logic l, input logic s, input logic y);
    pfmMode = p; hsOn = h; lsOn = l; ssDone = s; cycleSync = y;
  endtask

  task automatic finish;
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish();
    end
  end

  initial begin
    rstN = 1'b0;
    setIn(0, 1, 0, 1, 0);
    repeat (3) @(negedge clk);
    check("R1 gateEn", gateEn, 11'h7FF);
    check("R1 csPreset", {10'b0, csPreset}, 11'h000);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      setIn(VEC[i][14], VEC[i][13], VEC[i][12], VEC[i][11], 1'b1);
      @(negedge clk);
      cycleSync = 1'b0;
      check(vecTag(i), gateEn, VEC[i][10:0]);
      if (VEC[i][11]) check("R3", {10'b0, gateEn[10]}, 11'h000);
    end

    // R9: no change before the edge, change right after it
    setIn(0, 1, 0, 1, 1);
    @(negedge clk);
    setIn(1, 0, 0, 1, 0);
    #5 check("R9 before edge", gateEn, 11'h3FB);
    @(negedge clk);
    check("R9 after edge", gateEn, 11'h200);

    // R10: preset pulse on current-sense turn-off, full length
    setIn(0, 1, 0, 1, 1);
    @(negedge clk);
    setIn(0, 0, 1, 1, 1);
    @(negedge clk);
    cycleSync = 1'b0;
    check("R10 enable fell", {10'b0, gateEn[0]}, 11'h000);
    check("R10 preset cycle1", {10'b0, csPreset}, 11'h001);
    @(negedge clk);
    check("R10 preset cycle2", {10'b0, csPreset}, 11'h001);
    @(negedge clk);
    check("R10 preset ended", {10'b0, csPreset}, 11'h000);

    // R10: truncated by early re-enable
    setIn(0, 1, 0, 1, 1);
    @(negedge clk);
    setIn(0, 0, 1, 1, 1);
    @(negedge clk);
    check("R10 trunc start", {10'b0, csPreset}, 11'h001);
    setIn(0, 1, 0, 1, 1);
    @(negedge clk);
    check("R10 trunc cut", {10'b0, csPreset}, 11'h000);

    // R7 / R8: wake window timing with defaults 50 / 4
    setIn(0, 0, 1, 1, 1);
    @(negedge clk);
    cycleSync = 1'b0;
    repeat (46) @(negedge clk);
    check("R7 before window", gateEn, 11'h384);
    @(negedge clk);
    check("R7 window open", gateEn, 11'h3FF);
    repeat (30) @(negedge clk);
    check("R8 counter holds", gateEn, 11'h3FF);
    lsOn = 1'b0;
    @(negedge clk);
    check("R7 open phase wake", gateEn, 11'h3FF);
    cycleSync = 1'b1;
    @(negedge clk);
    cycleSync = 1'b0;
    check("R8 sync edge", gateEn, 11'h3FF);
    @(negedge clk);
    check("R8 restarted", gateEn, 11'h384);

    // R7: high-side phase ignores wake, PFM ignores wake
    repeat (50) @(negedge clk);
    hsOn = 1'b1;
    @(negedge clk);
    check("R7 high phase", gateEn, 11'h3FB);
    setIn(1, 0, 0, 1, 0);
    @(negedge clk);
    check("R6 pfm no wake", gateEn, 11'h200);

    // R1: reset mid-run
    rstN = 1'b0;
    @(negedge clk);
    check("R1 re-reset", gateEn, 11'h7FF);
    rstN = 1'b1;

    finish();
  end

endmodule